// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms a byte address from up to three terms: a base register value, an index register value shifted left by a two-bit scale code, and a signed displacement. Two presence flags select whether the base and the index take part. This lets one adder path cover all five operand forms: displacement alone, base alone, base plus displacement, base plus index, and base plus scaled index plus displacement.

An issue stage presents the operand fields together with `in_valid`. One clock later the sum appears on `out_addr` with `out_valid` high for one cycle. The sum wraps on overflow. A flag, `scale_bad`, travels with the result. It marks a request that names a scale factor other than 1 while no index term is present, because in that case the scale has nothing to act on. The registered outputs keep their last values until the next valid request arrives.

Top module: `ea_scaled_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0, `out_addr` is 0 and `scale_bad` is 0.
- R2: `out_valid` is 1 in the cycle after `in_valid` was 1, and it is 0 in the cycle after `in_valid` was 0. Back-to-back requests each produce their own result.
- R3: The result is the sign-extended displacement, plus the base if `use_base` is 1, plus the scaled index if `use_index` is 1.
- R4: The scale code multiplies the index by 1, 2, 4 or 8 for codes 00, 01, 10 and 11 respectively.
- R5: The displacement is a signed field. Its top bit is copied into every higher bit of the address before the addition.
- R6: When the presence flag of the base or the index is 0, that term adds zero, whatever value is on its input.
- R7: The sum, including bits that the index shift pushes out, is taken modulo 2^ADDR_W.
- R8: While `in_valid` is 0, `out_addr` and `scale_bad` keep their previous values, whatever the other inputs do.
- R9: `scale_bad` is 1 for a request with `use_index` 0 and a nonzero scale code, and 0 for every other request. It is registered together with the address, and the address is still computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| use_base | input | 1 | Include the base term |
| use_index | input | 1 | Include the scaled index term |
| base_val | input | ADDR_W | Base register value |
| index_val | input | ADDR_W | Index register value |
| scale_code | input | 2 | Index scale: 00=1, 01=2, 10=4, 11=8 |
| disp | input | DISP_W | Signed displacement |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | ADDR_W | Computed byte address |
| scale_bad | output | 1 | Scale given without an index term |

## Verification
The bench builds the unit with its default widths: a 64-bit address and a 32-bit displacement. The sign boundary is therefore at bit 31, and wraparound happens at 2^64. With these widths the test vectors can use the most negative displacement, a sum that carries out of bit 63, and an index whose top bits are shifted out by a scale of 8. Each of these shows whether the truncation and the sign extension happen at the right width.

// File: rtl/ea_scaled_gen.sv
module ea_scaled_gen #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              use_base,
  input  logic              use_index,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [1:0]        scale_code,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              scale_bad
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_term, base_term, index_term, sum;
  logic              bad_now;

  assign disp_term  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign base_term  = use_base  ? base_val : '0;
  assign index_term = use_index ? (index_val << scale_code) : '0;
  assign sum        = disp_term + base_term + index_term;
  assign bad_now    = !use_index && (scale_code != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      scale_bad <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= sum;
        scale_bad <= bad_now;
      end
    end
  end

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(scale_bad)));
  a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (scale_bad == ($past(!use_index) && ($past(scale_code) != 2'b00))));
  a_r6_disp_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_base && !use_index) |=>
      (out_addr == {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)}));
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_addr == '0 && !scale_bad));

endmodule

// File: tb/ea_scaled_gen_test.sv
module ea_scaled_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        use_base = 1'b0;
  logic        use_index = 1'b0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        scale_bad;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  ea_scaled_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_base(use_base),
    .use_index(use_index), .base_val(base_val), .index_val(index_val),
    .scale_code(scale_code), .disp(disp), .out_valid(out_valid),
    .out_addr(out_addr), .scale_bad(scale_bad)
  );

  typedef struct packed {
    logic        ub;
    logic        ui;
    logic [1:0]  sc;
    logic [63:0] b;
    logic [63:0] x;
    logic [31:0] d;
    logic [63:0] e;
    logic        bad;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b1, 2'd2, 64'h100, 64'h3, 32'h0, 64'h10C, 1'b0},
    '{1'b1, 1'b1, 2'd0, 64'h100, 64'h3, 32'h9, 64'h10C, 1'b0},
    '{1'b1, 1'b1, 2'd0, 64'h1, 64'h3, 32'h104, 64'h108, 1'b0},
    '{1'b0, 1'b0, 2'd0, 64'hDEAD, 64'hBEEF, 32'h104, 64'h104, 1'b0},
    '{1'b1, 1'b0, 2'd0, 64'h100, 64'h55, 32'h0, 64'h100, 1'b0},
    '{1'b1, 1'b0, 2'd0, 64'h100, 64'h0, 32'hFFFFFFFC, 64'hFC, 1'b0},
    '{1'b1, 1'b1, 2'd3, 64'h1000, 64'h4, 32'h0, 64'h1020, 1'b0},
    '{1'b0, 1'b1, 2'd1, 64'h777, 64'h5, 32'h0, 64'hA, 1'b0},
    '{1'b1, 1'b1, 2'd0, 64'hFFFFFFFFFFFFFFF0, 64'h20, 32'h0, 64'h10, 1'b0},
    '{1'b0, 1'b1, 2'd3, 64'h0, 64'h2000000000000001, 32'h0, 64'h8, 1'b0},
    '{1'b1, 1'b0, 2'd2, 64'h40, 64'h7, 32'h0, 64'h40, 1'b1},
    '{1'b0, 1'b0, 2'd0, 64'h0, 64'h0, 32'h80000000, 64'hFFFFFFFF80000000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    use_base = v.ub; use_index = v.ui; scale_code = v.sc;
    base_val = v.b; index_val = v.x; disp = v.d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1 out_addr in reset", out_addr, 64'd0);
    chk("R1 scale_bad in reset", {63'd0, scale_bad}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", {63'd0, out_valid}, 64'd0);

    // R3 R4 R5 R6 R7 R9: table walk, one request at a time
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 strobe", {63'd0, out_valid}, 64'd1);
      chk("R3 address", out_addr, VT[i].e);
      chk("R9 flag", {63'd0, scale_bad}, {63'd0, VT[i].bad});
    end

    // R8: inputs change without in_valid; outputs hold
    drive(VT[0]);
    @(negedge clk);
    chk("R2 idle strobe", {63'd0, out_valid}, 64'd0);
    chk("R8 address holds", out_addr, VT[NV-1].e);
    chk("R8 flag holds", {63'd0, scale_bad}, 64'd0);

    // R2: back-to-back requests
    @(negedge clk);
    drive(VT[10]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VT[6]);
    chk("R2 first of pair", out_addr, VT[10].e);
    chk("R9 first of pair", {63'd0, scale_bad}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second of pair", out_addr, VT[6].e);
    chk("R9 second clears", {63'd0, scale_bad}, 64'd0);
    chk("R2 second strobe", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R2 strobe drops", {63'd0, out_valid}, 64'd0);

    // R5 R7: negative displacement pulling base below zero wraps
    drive('{1'b1, 1'b0, 2'd0, 64'h4, 64'h0, 32'hFFFFFFF0, 64'h0, 1'b0});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 wrap below zero", out_addr, 64'hFFFFFFFFFFFFFFF4);

    // R1: reset in mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears address", out_addr, 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

endmodule